// File: doc/BRIEF.md
# Alternating-Order Multi-Level 2-D Haar Scheduler

This block runs a multi-level forward 2-D Haar transform in place on a square frame held in an external single-port memory. Each level is made of a row pass and a column pass. Odd levels run rows first and then columns, and even levels run columns first and then rows. Because the order flips at every level, the closing pass of one level and the opening pass of the next run in the same direction. The block folds them into a single scan of the frame.

During a folded scan, every high-pass result goes back to frame memory at once. The low-pass results of each line that also belongs to the next level are kept in an internal line buffer of N/2 words. Once that line is complete, the next level's pass runs from the buffer. Only its outputs are written back. This leaves one read and one write per sample for each scan, and the frame traffic falls below that of a plain row-then-column engine.

The transform is applied by pulsing a start input while the block is idle. The block then runs to completion and signals the end with a one-cycle done pulse. A status pair reports the level being computed and the direction of the current pass.

Top module: `haar2d_alt_sched`

## Requirements
- R1: While rst_ni is low, and in the first idle cycle after it is released, busy_o, done_o and mem_req_o are 0. An asynchronous reset during a run returns the block to idle.
- R2: Each pass combines sample pairs (a at even index, b at odd index) into L = (a+b)>>>1 and H = (a-b)>>>1. Both results are W-bit two's complement, rounded toward minus infinity. L overwrites a's location and H overwrites b's location.
- R3: Level v (1..J) works on the samples whose row and column are multiples of 2^(v-1), over a region of N>>(v-1) samples per side. Odd levels run the row pass and then the column pass. Even levels run the column pass and then the row pass. Frame word address = row*N + column.
- R4: After a run, the frame equals the result of executing every pass of R3 separately, one after another, in that order.
- R5: One run issues exactly N² + Σ_{k=0..J-1}(N>>k)² reads and the same number of writes. The total is (2 + 2·Σ_{k=0..J-1} 4^-k)·N² accesses, which is below the 4·Σ 4^-k·N² of a plain row-then-column engine.
- R6: In a folded scan, the low-pass outputs of even-index lines are held in the line buffer instead of being written. The next level's pass on a line starts only when the buffer holds all N>>v of that line's words. The buffer never overflows and never underflows.
- R7: Read data is taken from mem_rdata_i in the cycle after the read request. At most one memory access is issued per cycle.
- R8: busy_o is high from the cycle after start_i is accepted until the run ends. done_o is a single-cycle pulse in the first idle cycle after the run. start_i is ignored while busy_o is high.
- R9: level_o gives the level being computed (1..J) and dir_o gives the pass direction (0 row, 1 column). The pairs (level, direction) first appear in the order of R3.
- R10: No memory access is issued while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a run when idle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| mem_req_o | output | 1 | Frame memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 2*log2(N) | Frame word address, row*N + column |
| mem_wdata_o | output | W | Write data |
| mem_rdata_i | input | W | Read data, valid one cycle after a read request |
| level_o | output | log2(J+1) | Level being computed |
| dir_o | output | 1 | Pass direction, 0 row, 1 column |

## Verification
The following are checked on every cycle:
- The line buffer never writes past N/2 words and never reads a word it has not been given.
- A buffered pass begins only on a full line.
- done_o lasts one cycle.
- level_o stays inside 1..J.
- Memory stays silent while idle.
- Every writeback of a pair follows two reads.

Only the bench's scenarios can show that the folded scans leave the frame identical to the separate-pass result under constant, checkerboard, ramp and hashed images. The same holds for the exact access totals, the order in which levels and directions appear, floor rounding of negative high-pass values, and a start pulse during a run being ignored.

// File: rtl/haar_sched_pkg.sv
package haar_sched_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_A, ST_RD_B, ST_WR_L, ST_WR_H, ST_BF_A, ST_BF_L, ST_BF_H
  } sched_st_e;

  localparam logic DIR_ROW = 1'b0;
  localparam logic DIR_COL = 1'b1;
endpackage

// File: rtl/haar_butterfly.sv
module haar_butterfly #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  logic [W:0] sum, dif;

  // one guard bit, then drop the LSB: arithmetic shift with floor rounding
  assign sum  = {a_i[W-1], a_i} + {b_i[W-1], b_i};
  assign dif  = {a_i[W-1], a_i} - {b_i[W-1], b_i};
  assign lo_o = sum[W:1];
  assign hi_o = dif[W:1];
endmodule

// File: rtl/haar_line_buf.sv
module haar_line_buf #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_en_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             rd_en_i,
  output logic [W-1:0]     rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] fill_o
);
  localparam int PTRW = $clog2(DEPTH + 1);
  localparam int IW   = $clog2(DEPTH);

  logic [W-1:0]    store [DEPTH];
  logic [PTRW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en_i) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en_i) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !clr_i) store[wr_ptr[IW-1:0]] <= wdata_i;
  end

  assign rdata_o = store[rd_ptr[IW-1:0]];
  assign fill_o  = wr_ptr;

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_ptr < PTRW'(DEPTH)));
  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> (rd_ptr < wr_ptr));
endmodule

// File: rtl/haar_addr_gen.sv
module haar_addr_gen
  import haar_sched_pkg::*;
#(
  parameter int LG = 6
) (
  input  logic            dir_i,
  input  logic [LG-1:0]   line_i,
  input  logic [LG-1:0]   samp_i,
  output logic [2*LG-1:0] addr_o
);
  // row pass: line = row, sample = column; column pass swaps them
  assign addr_o = (dir_i == DIR_COL) ? {samp_i, line_i} : {line_i, samp_i};
endmodule

// File: rtl/haar2d_alt_sched.sv
module haar2d_alt_sched
  import haar_sched_pkg::*;
#(
  parameter int N = 64,
  parameter int J = 3,
  parameter int W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [2*$clog2(N)-1:0]   mem_addr_o,
  output logic [W-1:0]             mem_wdata_o,
  input  logic [W-1:0]             mem_rdata_i,
  output logic [$clog2(J+1)-1:0]   level_o,
  output logic                     dir_o
);
  localparam int LG = $clog2(N);
  localparam int AW = 2 * LG;
  localparam int PW = $clog2(J + 1);
  localparam int HD = N / 2;
  localparam int FW = $clog2(HD + 1);

  sched_st_e       state_q;
  logic [PW-1:0]   phase_q;
  logic [LG-1:0]   line_q, pair_q, bq_q;
  logic [W-1:0]    a_q, h_q;
  logic            done_q;

  logic [PW-1:0]   lvl, sh;
  logic [LG-1:0]   size_m1, half_m1, quart_m1;
  logic            fused, buffered, pair_last, bq_last, line_last, phase_last, line_end;
  logic [LG-1:0]   line_c, samp_ev, samp_od, samp_bev, samp_bod, samp_c;
  logic [W-1:0]    bf_b, lo, hi, buf_rdata;
  logic [FW-1:0]   buf_fill, half_fill;
  logic            buf_clr, buf_wr, buf_rd;

  // phase 0 = first pass of level 1, phase k = closing pass of level k (+ opening of k+1)
  assign lvl        = (phase_q == '0) ? PW'(1) : phase_q;
  assign sh         = lvl - 1'b1;
  assign size_m1    = LG'((N >> sh) - 1);
  assign half_m1    = LG'((N >> (32'(sh) + 1)) - 1);
  assign quart_m1   = LG'((N >> (32'(sh) + 2)) - 1);
  assign half_fill  = FW'(N >> (32'(sh) + 1));
  assign fused      = (phase_q != '0) && (phase_q != PW'(J));
  assign buffered   = fused && !line_q[0];
  assign pair_last  = (pair_q == half_m1);
  assign bq_last    = (bq_q == quart_m1);
  assign line_last  = (line_q == size_m1);
  assign phase_last = (phase_q == PW'(J));
  assign line_end   = ((state_q == ST_WR_H) && pair_last && !buffered) ||
                      ((state_q == ST_BF_H) && bq_last);

  assign line_c   = line_q << sh;
  assign samp_ev  = {pair_q[LG-2:0], 1'b0} << sh;
  assign samp_od  = {pair_q[LG-2:0], 1'b1} << sh;
  assign samp_bev = {bq_q[LG-2:0], 1'b0} << (sh + 1'b1);
  assign samp_bod = {bq_q[LG-2:0], 1'b1} << (sh + 1'b1);

  assign bf_b = (state_q == ST_BF_L) ? buf_rdata : mem_rdata_i;

  haar_butterfly #(.W(W)) u_bfly (
    .a_i (a_q),
    .b_i (bf_b),
    .lo_o(lo),
    .hi_o(hi)
  );

  assign buf_clr = (state_q == ST_RD_A) && (pair_q == '0);
  assign buf_wr  = (state_q == ST_WR_L) && buffered;
  assign buf_rd  = (state_q == ST_BF_A) || (state_q == ST_BF_L);

  haar_line_buf #(.W(W), .DEPTH(HD)) u_lbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (buf_clr),
    .wr_en_i(buf_wr),
    .wdata_i(lo),
    .rd_en_i(buf_rd),
    .rdata_o(buf_rdata),
    .fill_o (buf_fill)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = lo;
    samp_c      = samp_ev;
    unique case (state_q)
      ST_RD_A: mem_req_o = 1'b1;
      ST_RD_B: begin mem_req_o = 1'b1; samp_c = samp_od; end
      ST_WR_L: begin mem_req_o = !buffered; mem_we_o = 1'b1; end
      ST_WR_H: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; samp_c = samp_od; mem_wdata_o = h_q;
      end
      ST_BF_L: begin mem_req_o = 1'b1; mem_we_o = 1'b1; samp_c = samp_bev; end
      ST_BF_H: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; samp_c = samp_bod; mem_wdata_o = h_q;
      end
      default: ;
    endcase
  end

  haar_addr_gen #(.LG(LG)) u_agen (
    .dir_i (phase_q[0]),
    .line_i(line_c),
    .samp_i(samp_c),
    .addr_o(mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      line_q  <= '0;
      pair_q  <= '0;
      bq_q    <= '0;
      a_q     <= '0;
      h_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RD_A;
          phase_q <= '0;
          line_q  <= '0;
          pair_q  <= '0;
        end
        ST_RD_A: state_q <= ST_RD_B;
        ST_RD_B: begin a_q <= mem_rdata_i; state_q <= ST_WR_L; end
        ST_WR_L: begin h_q <= hi; state_q <= ST_WR_H; end
        ST_WR_H: begin
          if (!pair_last) begin
            pair_q  <= pair_q + 1'b1;
            state_q <= ST_RD_A;
          end else if (buffered) begin
            bq_q    <= '0;
            state_q <= ST_BF_A;
          end
        end
        ST_BF_A: begin a_q <= buf_rdata; state_q <= ST_BF_L; end
        ST_BF_L: begin h_q <= hi; state_q <= ST_BF_H; end
        ST_BF_H: if (!bq_last) begin
          bq_q    <= bq_q + 1'b1;
          state_q <= ST_BF_A;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (line_end) begin
        pair_q <= '0;
        if (!line_last) begin
          line_q  <= line_q + 1'b1;
          state_q <= ST_RD_A;
        end else if (phase_last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          phase_q <= phase_q + 1'b1;
          line_q  <= '0;
          state_q <= ST_RD_A;
        end
      end
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign dir_o   = phase_q[0];
  assign level_o = (state_q inside {ST_BF_A, ST_BF_L, ST_BF_H}) ? phase_q + 1'b1 : lvl;

  assert_full_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BF_A && bq_q == '0) |-> (buf_fill == half_fill));
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_level_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (level_o >= PW'(1) && level_o <= PW'(J)));
  assert_rd_before_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR_L) |-> ($past(mem_req_o) && !$past(mem_we_o)));
endmodule

// File: tb/haar2d_alt_sched_test.sv
`timescale 1ns/1ps
module haar2d_alt_sched_test;
  localparam int N  = 64;
  localparam int J  = 3;
  localparam int W  = 16;
  localparam int NN = N * N;
  localparam int AW = 2 * $clog2(N);
  localparam int PW = $clog2(J + 1);

  // {kind[31:28], poke_start[27:24], seed[23:16], expected accesses[15:0]}
  localparam logic [31:0] VEC [4] = '{
    {4'd0, 4'd0, 8'd77,  16'd18944},
    {4'd1, 4'd1, 8'd0,   16'd18944},
    {4'd2, 4'd0, 8'd9,   16'd18944},
    {4'd3, 4'd1, 8'h5a,  16'd18944}
  };

  logic clk = 1'b0;
  logic rst_ni, start_i, busy, done, mem_req, mem_we, dir;
  logic [AW-1:0] mem_addr;
  logic [W-1:0]  mem_wdata, mem_rdata;
  logic [PW-1:0] level;

  logic signed [W-1:0] fmem [NN];
  int rd_cnt, wr_cnt, cyc;
  int seen_at [2*J];
  logic load_go;
  int cur_kind, cur_seed;
  int n_chk = 0, n_fail = 0;
  int rm [NN];

  always #4 clk = ~clk;

  haar2d_alt_sched #(.N(N), .J(J), .W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy), .done_o(done),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .level_o(level), .dir_o(dir)
  );

  function automatic int pat(int kind, int seed, int i);
    int r = i / N;
    int c = i % N;
    int unsigned x;
    case (kind)
      0: return seed & 255;
      1: return (((r ^ c) & 1) != 0) ? 255 : 0;
      2: return (r * 3 + c * 5 + seed) & 255;
      default: begin
        x = 32'(i) * 32'd2654435761 ^ 32'(seed) * 32'd40503;
        x = x ^ (x >> 15);
        x = x * 32'd2246822519;
        x = x ^ (x >> 13);
        return int'(x & 32'd255);
      end
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (load_go) begin
      for (int i = 0; i < NN; i++) fmem[i] <= W'(pat(cur_kind, cur_seed, i));
      rd_cnt <= 0;
      wr_cnt <= 0;
      for (int k = 0; k < 2*J; k++) seen_at[k] <= -1;
    end else begin
      if (mem_req) begin
        if (mem_we) begin
          fmem[mem_addr] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rdata <= fmem[mem_addr];
          rd_cnt <= rd_cnt + 1;
        end
      end
      if (busy && level >= PW'(1) && level <= PW'(J))
        if (seen_at[(int'(level) - 1) * 2 + int'(dir)] < 0)
          seen_at[(int'(level) - 1) * 2 + int'(dir)] <= cyc;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic ref_pass(input int v, input int d);
    int sh = v - 1;
    int s  = N >> sh;
    for (int l = 0; l < s; l++)
      for (int p = 0; p < s / 2; p++) begin
        int lc = l << sh;
        int s0 = (2 * p) << sh;
        int s1 = (2 * p + 1) << sh;
        int ia = (d == 0) ? lc * N + s0 : s0 * N + lc;
        int ib = (d == 0) ? lc * N + s1 : s1 * N + lc;
        int a = rm[ia];
        int b = rm[ib];
        rm[ia] = (a + b) >>> 1;
        rm[ib] = (a - b) >>> 1;
      end
  endtask

  task automatic ref_run();
    for (int i = 0; i < NN; i++) rm[i] = pat(cur_kind, cur_seed, i);
    for (int v = 1; v <= J; v++) begin
      int fd = (v % 2 == 1) ? 0 : 1;
      ref_pass(v, fd);
      ref_pass(v, 1 - fd);
    end
  endtask

  task automatic run_vec(input logic [31:0] vec);
    int poke = int'(vec[27:24]);
    int exp_tot = int'(vec[15:0]);
    int formula, direct, bad, first_bad, viol, prev;
    bit got_done = 0;
    cur_kind = int'(vec[31:28]);
    cur_seed = int'(vec[23:16]);
    @(negedge clk); load_go = 1'b1;
    @(negedge clk); load_go = 1'b0;
    ref_run();
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    for (int t = 0; t < 40000 && !got_done; t++) begin
      @(negedge clk);
      start_i = (poke != 0 && t == 1000);
      got_done = done;
    end
    start_i = 1'b0;
    chk(got_done, "R8 watchdog: run finished", int'(got_done), 1);
    // R4: frame equals separate passes in alternating order
    bad = 0; first_bad = -1;
    for (int i = 0; i < NN; i++)
      if (int'(fmem[i]) != rm[i]) begin
        if (first_bad < 0) first_bad = i;
        bad++;
      end
    chk(bad == 0, "R4 frame mismatched words", bad, 0);
    if (first_bad >= 0)
      $display("  first mismatch at %0d: %0d vs %0d", first_bad, int'(fmem[first_bad]), rm[first_bad]);
    // R5: access totals
    formula = 2 * NN; direct = 0;
    for (int k = 0; k < J; k++) begin
      formula += 2 * (N >> k) * (N >> k);
      direct  += 4 * (N >> k) * (N >> k);
    end
    chk(formula == exp_tot, "R5 bandwidth formula", formula, exp_tot);
    chk(rd_cnt == exp_tot / 2, "R5 reads", rd_cnt, exp_tot / 2);
    chk(wr_cnt == exp_tot / 2, "R5 writes", wr_cnt, exp_tot / 2);
    chk(rd_cnt + wr_cnt < direct, "R5 below row-column traffic", rd_cnt + wr_cnt, direct);
    // R9/R3: first appearance order of (level, dir)
    viol = 0; prev = -1;
    for (int v = 1; v <= J; v++) begin
      int fd = (v % 2 == 1) ? 0 : 1;
      int ia = seen_at[(v - 1) * 2 + fd];
      int ib = seen_at[(v - 1) * 2 + 1 - fd];
      if (ia < 0 || ia <= prev) viol++;
      if (ib < 0 || ib <= ia) viol++;
      prev = ib;
    end
    chk(viol == 0, "R9 R3 level/direction order violations", viol, 0);
    if (cur_kind == 0) begin
      chk(int'(fmem[0]) == cur_seed, "R2 constant image DC", int'(fmem[0]), cur_seed);
      chk(int'(fmem[1]) == 0, "R2 constant image detail", int'(fmem[1]), 0);
    end
    if (cur_kind == 1)
      chk(int'(fmem[1]) == -1, "R2 negative floor rounding", int'(fmem[1]), -1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single pulse", int'(done), 0);
    chk(busy == 1'b0, "R8 idle after run", int'(busy), 0);
    chk(mem_req == 1'b0, "R10 no access when idle", int'(mem_req), 0);
  endtask

  initial begin
    #1560000;
    n_chk++;
    n_fail++;
    $display("FAIL R8 global watchdog expired: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; load_go = 1'b0;
    cur_kind = 0; cur_seed = 0; cyc = 0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    chk(mem_req == 1'b0, "R1 mem_req in reset", int'(mem_req), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && mem_req == 1'b0, "R1 idle after release", int'(busy), 0);

    for (int v = 0; v < 4; v++) run_vec(VEC[v]);

    // R1: reset in the middle of a run
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (200) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(busy == 1'b0, "R1 async reset mid-run busy", int'(busy), 0);
    chk(mem_req == 1'b0, "R1 async reset mid-run mem_req", int'(mem_req), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 idle after mid-run reset", int'(busy), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule